// File: doc/BRIEF.md
# Addressable Latch with Decode Modes

This block holds an eight-bit word in level-sensitive storage cells. A single data bit is steered into one cell, which a three-bit address picks. Every cell drives its own output line. A bit stream can therefore be written one address at a time and then read back as one parallel word.

Two control inputs choose one of four modes. Both are active low by default: a latch enable and a clear. The modes work as follows:

- **WRITE**: the addressed cell is transparent to the data input.
- **HOLD**: every cell keeps its value.
- **DECODE**: the block acts as a 3-to-8 demultiplexer. The addressed output carries the data bit and all others are low.
- **CLEAR**: every cell is emptied.

Mode changes are combinational. There is no clock. The mode is modelled as an enumerated state (`MODE_WRITE`, `MODE_HOLD`, `MODE_DECODE`, `MODE_CLEAR`), and it changes as soon as the control pair changes. The named transitions are:

- WRITE→HOLD: freeze the word.
- CLEAR→HOLD: keep zeros.
- DECODE→HOLD: keep the decoded pattern.
- An address change inside WRITE: the old cell freezes and the new cell opens.

Top module: `addr_latch`

## Requirements
- R1: The control pair selects the mode: enable low with clear high is WRITE, both high is HOLD, both low is DECODE, and enable high with clear low is CLEAR.
- R2: In WRITE, output bit `sel_addr` follows `din` while it is addressed, and every other output keeps its previous value.
- R3: In HOLD, the outputs do not change whatever `din` and `sel_addr` do.
- R4: In DECODE, output bit `sel_addr` equals `din` and all other outputs are 0, so with `din` = 1 the outputs form a one-hot code of the address (bit n set for address n).
- R5: In CLEAR, all outputs are 0 whatever `din` and `sel_addr` do.
- R6: The storage itself is emptied in CLEAR, so moving from CLEAR to HOLD shows all zeros.
- R7: DECODE also writes its pattern into storage: non-addressed cells become 0 and the addressed cell takes `din`, and a move to HOLD keeps that pattern.
- R8: When `sel_addr` changes in WRITE while `din` is steady, the previously addressed cell keeps the value it had just before the change.
- R9: Eight WRITE steps, one per address, followed by HOLD, present the written bits as one parallel word, with address n on output bit n.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| latch_en_n | input | 1 | Latch enable, active low by default |
| clear_n | input | 1 | Clear control, active low by default |
| sel_addr | input | 3 | Cell address |
| din | input | 1 | Data bit |
| dout | output | 8 | Stored word, bit n from cell n |

## Verification
Two functions can act together on the same change:

- **Storage update and output forcing.** In DECODE and CLEAR the outputs are forced while the cells are rewritten underneath them.
- **Freezing and opening.** An address change inside WRITE freezes one cell and opens another in the same step.

The bench provokes both cases. It goes from DECODE or CLEAR straight into HOLD, which shows the hidden storage. It also moves the address while `din` stays high and then drops `din`. Each outcome is judged against a requirement-level model of the eight cells, with the outputs sampled half a clock after each input change.

// File: rtl/addr_latch_pkg.sv
package addr_latch_pkg;
    typedef enum logic [1:0] {
        MODE_WRITE  = 2'd0,
        MODE_HOLD   = 2'd1,
        MODE_DECODE = 2'd2,
        MODE_CLEAR  = 2'd3
    } mode_e;
endpackage

// File: rtl/alch_mode_decode.sv
module alch_mode_decode #(
    parameter bit ENABLE_LOW = 1'b1,
    parameter bit CLEAR_LOW  = 1'b1
) (
    input  logic                  en_pin,
    input  logic                  clr_pin,
    output addr_latch_pkg::mode_e mode
);
    import addr_latch_pkg::*;

    logic en_act;
    logic clr_act;

    assign en_act  = ENABLE_LOW ? ~en_pin  : en_pin;
    assign clr_act = CLEAR_LOW  ? ~clr_pin : clr_pin;

    always_comb begin
        unique case ({clr_act, en_act})
            2'b01:   mode = MODE_WRITE;
            2'b00:   mode = MODE_HOLD;
            2'b11:   mode = MODE_DECODE;
            default: mode = MODE_CLEAR;
        endcase
    end

    always_comb begin
        if (!$isunknown({en_pin, clr_pin})) begin
            AST_CLEAR_MODE: assert (!clr_act || mode inside {MODE_DECODE, MODE_CLEAR}); // R1
        end
    end
endmodule

// File: rtl/alch_cell.sv
module alch_cell (
    input  addr_latch_pkg::mode_e mode,
    input  logic                  sel,
    input  logic                  din,
    output logic                  q
);
    import addr_latch_pkg::*;

    logic open;
    logic nxt;

    assign open = ((mode == MODE_WRITE) && sel) || (mode == MODE_DECODE) || (mode == MODE_CLEAR);
    assign nxt  = (mode != MODE_CLEAR) && sel && din;

    always_latch begin
        if (open) q = nxt;
    end

    always_comb begin
        if (!$isunknown({mode, q})) begin
            AST_CELL_EMPTIED: assert (mode != MODE_CLEAR || q == 1'b0); // R6
            AST_DECODE_STORE: assert (mode != MODE_DECODE || sel || q == 1'b0); // R7
        end
    end
endmodule

// File: rtl/alch_out_mux.sv
module alch_out_mux #(
    parameter int WIDTH = 8
) (
    input  addr_latch_pkg::mode_e mode,
    input  logic [WIDTH-1:0]      sel_vec,
    input  logic                  din,
    input  logic [WIDTH-1:0]      cells,
    output logic [WIDTH-1:0]      dout
);
    import addr_latch_pkg::*;

    logic [WIDTH-1:0] demux;

    assign demux = sel_vec & {WIDTH{din}};

    always_comb begin
        unique case (mode)
            MODE_WRITE:  dout = cells;
            MODE_HOLD:   dout = cells;
            MODE_DECODE: dout = demux;
            default:     dout = '0;
        endcase
    end
endmodule

// File: rtl/addr_latch.sv
module addr_latch #(
    parameter int WIDTH      = 8,
    parameter bit ENABLE_LOW = 1'b1,
    parameter bit CLEAR_LOW  = 1'b1,
    localparam int ADDR_W    = $clog2(WIDTH)
) (
    input  logic              latch_en_n,
    input  logic              clear_n,
    input  logic [ADDR_W-1:0] sel_addr,
    input  logic              din,
    output logic [WIDTH-1:0]  dout
);
    import addr_latch_pkg::*;

    mode_e            mode;
    logic [WIDTH-1:0] sel_vec;
    logic [WIDTH-1:0] cells;

    alch_mode_decode #(
        .ENABLE_LOW (ENABLE_LOW),
        .CLEAR_LOW  (CLEAR_LOW)
    ) u_mode (
        .en_pin  (latch_en_n),
        .clr_pin (clear_n),
        .mode    (mode)
    );

    for (genvar i = 0; i < WIDTH; i++) begin : g_cell
        assign sel_vec[i] = (sel_addr == ADDR_W'(i));
        alch_cell u_cell (
            .mode (mode),
            .sel  (sel_vec[i]),
            .din  (din),
            .q    (cells[i])
        );
    end

    alch_out_mux #(.WIDTH(WIDTH)) u_out (
        .mode    (mode),
        .sel_vec (sel_vec),
        .din     (din),
        .cells   (cells),
        .dout    (dout)
    );

    always_comb begin
        if (!$isunknown({latch_en_n, clear_n, sel_addr, din, dout})) begin
            AST_WRITE_FOLLOW: assert (mode != MODE_WRITE || dout[sel_addr] == din); // R2
            AST_HOLD_STORED:  assert (mode != MODE_HOLD || dout == cells); // R3
            AST_DECODE_ONEHOT: assert (mode != MODE_DECODE || ($onehot0(dout) && dout[sel_addr] == din)); // R4
            AST_CLEAR_LOW:    assert (mode != MODE_CLEAR || $countones(dout) == 0); // R5
        end
    end
endmodule

// File: tb/test_addr_latch.sv
module test_addr_latch;
    logic       clk = 1'b0;
    logic       latch_en_n = 1'b1;
    logic       clear_n = 1'b0;
    logic [2:0] sel_addr = 3'd0;
    logic       din = 1'b0;
    logic [7:0] dout;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    typedef struct {
        logic [7:0] exp;
        string      tag;
    } item_t;

    item_t      sb[$];
    logic [7:0] model = 8'h00;

    always #2 clk = ~clk;

    addr_latch i_addr_latch (
        .latch_en_n (latch_en_n),
        .clear_n    (clear_n),
        .sel_addr   (sel_addr),
        .din        (din),
        .dout       (dout)
    );

    // mode codes: 0 write, 1 hold, 2 decode, 3 clear
    task automatic drive(input int m, input logic [2:0] a, input logic d, input string tag);
        logic [7:0] o;
        @(posedge clk);
        latch_en_n = (m == 1 || m == 3);
        clear_n    = (m == 0 || m == 1);
        sel_addr   = a;
        din        = d;
        case (m)
            0: begin model[a] = d; o = model; end
            1: o = model;
            2: begin model = 8'h00; model[a] = d; o = model; end
            default: begin model = 8'h00; o = 8'h00; end
        endcase
        sb.push_back('{exp: o, tag: tag});
    endtask

    always @(negedge clk) begin
        while (sb.size() > 0) begin
            item_t it;
            it = sb.pop_front();
            checks++;
            if (dout !== it.exp) begin
                fails++;
                $display("FAIL %s: dout=%h expected=%h", it.tag, dout, it.exp);
            end
        end
    end

    initial begin
        drive(3, 3'd3, 1'b1, "R5 reset state");
        drive(1, 3'd6, 1'b1, "R6 clear then hold");
        drive(0, 3'd2, 1'b1, "R1 write mode select");
        drive(0, 3'd2, 1'b0, "R2 follow low");
        drive(0, 3'd2, 1'b1, "R2 follow high");
        drive(0, 3'd6, 1'b1, "R8 address moves");
        drive(0, 3'd6, 1'b0, "R8 old cell frozen");
        drive(1, 3'd2, 1'b0, "R3 hold data low");
        drive(1, 3'd5, 1'b1, "R3 hold other address");
        drive(1, 3'd0, 1'b0, "R3 hold again");
        for (int i = 0; i < 8; i++) drive(0, 3'(i), (8'hA5 >> i) & 1'b1, "R9 serial load");
        drive(1, 3'd7, 1'b0, "R9 parallel word");
        for (int i = 0; i < 8; i++) drive(2, 3'(i), 1'b1, "R4 one-hot decode");
        drive(2, 3'd4, 1'b0, "R4 decode data low");
        drive(2, 3'd3, 1'b1, "R7 decode pattern");
        drive(1, 3'd0, 1'b0, "R7 decode then hold");
        drive(0, 3'd0, 1'b1, "R2 write after decode");
        drive(3, 3'd0, 1'b1, "R5 clear with data high");
        drive(3, 3'd5, 1'b0, "R5 clear other address");
        drive(1, 3'd5, 1'b1, "R6 clear then hold again");
        @(posedge clk);
        @(posedge clk);
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: run did not finish");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule